// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block takes one active-low external interrupt pin and turns it into a request for the CPU. A two-flop synchronizer brings the raw pin into the clock domain. The block then interprets the pin in one of two ways:

- **Level mode.** The request follows the synchronized pin while the pin is held low.
- **Edge mode.** A falling edge sets a pending flag. The flag stays set until the CPU acknowledges it with a one-cycle service strobe, or until reset.

Software configures the block through a one-byte control register. Bit 7 selects edge sensitivity and bit 6 connects the pin to the request logic. Bits 5 to 0 are reserved and read as zero.

A mode input sets how writes to the sensitivity bit behave. In special mode that bit can be rewritten freely. In normal or emulation mode only the first write after reset takes effect. The enable bit stays writable in every mode. The reset values of the sensitivity bit, the enable bit and the pending flag are parameters.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset `reg_rdata` equals {EDGE_RST, EN_RST, 6'b0} and `irq_req` is low (default parameters: all zero). The synchronizer resets to the idle (high) level.
- R2: A falling edge on `pin_n` reaches the edge detector after two synchronizer flops. In edge mode with the pin enabled, `irq_req` rises after the third rising clock edge that follows the pin drop.
- R3: In edge mode (control bit 7 = 1), a 1-to-0 transition of the synchronized pin between consecutive clocks sets the pending flag. `irq_req` equals enable AND pending.
- R4: The pending flag stays set through any pin activity until a `svc_ack` pulse, which clears it on the following clock edge.
- R5: If `svc_ack` falls in the same cycle as a newly detected falling edge, the pending flag stays set.
- R6: In level mode (control bit 7 = 0), `irq_req` is enable AND (synchronized pin == 0), and no edge is latched.
- R7: With enable (control bit 6) = 0, `irq_req` stays low in both modes. Edge detection still sets the pending flag, so setting enable later raises the request.
- R8: With `special_mode` = 0, only the first register write after reset updates bit 7. Later writes leave bit 7 unchanged.
- R9: With `special_mode` = 1, every write updates bit 7. Writes made in special mode do not use up the single normal-mode write.
- R10: Every register write updates bit 6 in either mode.
- R11: Bits 5 to 0 of `reg_rdata` always read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = special mode (unrestricted writes to bit 7) |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| pin_n | input | 1 | Raw active-low interrupt pin |
| svc_ack | input | 1 | One-cycle interrupt service strobe |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
Two events can land in the same cycle: the service strobe that clears a pending edge, and the detection of a fresh falling edge. The bench drops the pin and then fires `svc_ack` at each offset from zero to four cycles after the drop. One of those offsets falls exactly on the cycle where the edge is detected.

At every clock, a behavioural model built on a queue of pin samples predicts `irq_req` and the register value. At the coinciding offset the request must stay high. At the other offsets it must clear and then rise again, or simply clear.

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl #(
  parameter bit EDGE_RST = 1'b0,
  parameter bit EN_RST   = 1'b0,
  parameter bit PEND_RST = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       special_mode,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       pin_n,
  input  logic       svc_ack,
  output logic       irq_req
);
  logic [1:0] sync_q;
  logic       pin_d;
  logic       edge_sel, en, lock, pend;
  logic       pin_s, fall;

  assign pin_s = sync_q[1];
  assign fall  = pin_d & ~pin_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= 2'b11;
      pin_d  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], pin_n};
      pin_d  <= pin_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      edge_sel <= EDGE_RST;
      en       <= EN_RST;
      lock     <= 1'b0;
    end else if (reg_we) begin
      en <= reg_wdata[6];
      if (special_mode || !lock) edge_sel <= reg_wdata[7];
      if (!special_mode) lock <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pend <= PEND_RST;
    else if (edge_sel && fall) pend <= 1'b1;
    else if (svc_ack)          pend <= 1'b0;

  assign reg_rdata = {edge_sel, en, 6'b0};
  assign irq_req   = en & (edge_sel ? pend : ~pin_s);
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       special_mode,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       svc_ack,
  input logic       irq_req,
  input logic       fall,
  input logic       pend,
  input logic       lock
);
  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5:0] == 6'b0);

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[6] |-> !irq_req);

  p_en_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata[6] == $past(reg_wdata[6]));

  p_special_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && special_mode) |=> reg_rdata[7] == $past(reg_wdata[7]));

  p_write_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && reg_we && !special_mode) |=> $stable(reg_rdata[7]));

  p_fall_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && fall) |=> pend);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !svc_ack) |=> pend);

  p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && svc_ack && !(reg_rdata[7] && fall)) |=> !pend);
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .svc_ack(svc_ack),
  .irq_req(irq_req), .fall(fall), .pend(pend), .lock(lock)
);

// File: tb/irq_pin_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_pin_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special_mode = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       pin_n = 1'b1;
  logic       svc_ack = 1'b0;
  logic       irq_req;

  int  n_run = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  irq_pin_ctrl dut_i (.*);

  // behavioural reference model
  bit m_edge, m_en, m_lock, m_pend;
  bit q[$];
  bit exp_irq;
  logic [7:0] exp_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q = '{1'b1, 1'b1, 1'b1};
      m_edge = 0; m_en = 0; m_lock = 0; m_pend = 0;
    end else begin
      bit seen_fall;
      seen_fall = q[q.size()-3] && !q[q.size()-2];
      if (m_edge && seen_fall) m_pend = 1;
      else if (svc_ack) m_pend = 0;
      if (reg_we) begin
        m_en = reg_wdata[6];
        if (special_mode || !m_lock) m_edge = reg_wdata[7];
        if (!special_mode) m_lock = 1;
      end
      q.push_back(pin_n);
      if (q.size() > 8) void'(q.pop_front());
    end
    exp_rd  = {m_edge, m_en, 6'b0};
    exp_irq = m_en && (m_edge ? m_pend : !q[q.size()-2]);
  end

  always @(negedge clk) if (!done) begin
    cycles++;
    n_run++;
    if (irq_req !== exp_irq) begin
      n_fail++;
      $display("FAIL %s irq_req actual=%b expected=%b t=%0t", cur_req, irq_req, exp_irq, $time);
    end
    n_run++;
    if (reg_rdata !== exp_rd) begin
      n_fail++;
      $display("FAIL %s reg_rdata actual=%h expected=%h t=%0t", cur_req, reg_rdata, exp_rd, $time);
    end
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(bit sp, logic [7:0] d);
    special_mode = sp; reg_we = 1'b1; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic ack();
    svc_ack = 1'b1; step(); svc_ack = 1'b0;
  endtask

  task automatic pulse_low(int lo, int hi);
    pin_n = 1'b0; step(lo); pin_n = 1'b1; step(hi);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(2);
  endtask

  initial begin
    cur_req = "R1"; step(3); rst_n = 1'b1; step(4);
    cur_req = "R9"; wr(1, 8'hC0); step(); wr(1, 8'h40); step(); wr(1, 8'hC0); step();
    cur_req = "R11"; wr(1, 8'hFF); step(2);
    cur_req = "R2"; pulse_low(2, 6);
    cur_req = "R4"; pulse_low(3, 3); step(5); ack(); step(4);
    cur_req = "R3"; pulse_low(1, 6); ack(); step(3);
    for (int off = 0; off < 5; off++) begin
      cur_req = "R5";
      pin_n = 1'b0; step(off); ack(); step(5); pin_n = 1'b1; step(3); ack(); step(3);
    end
    cur_req = "R7"; wr(1, 8'h80); pulse_low(2, 6); step(3);
    wr(1, 8'hC0); step(4); ack(); step(3);
    cur_req = "R6"; wr(1, 8'h40); pulse_low(4, 5); pulse_low(1, 5);
    wr(1, 8'h00); pulse_low(3, 5);
    cur_req = "R8"; wr(0, 8'h40); wr(0, 8'hC0); step(2); wr(0, 8'h80); step(2);
    cur_req = "R10"; wr(0, 8'h40); pulse_low(3, 5);
    cur_req = "R9"; wr(1, 8'hC0); wr(0, 8'h40); step(2);
    cur_req = "R1"; do_reset();
    cur_req = "R8"; wr(0, 8'hC0); wr(0, 8'h00); wr(0, 8'h40); pulse_low(2, 6); ack(); step(3);
    cur_req = "R10"; wr(0, 8'h00); pulse_low(2, 5); wr(0, 8'h40); step(3);
    finish_run();
  end
endmodule